// File: doc/BRIEF.md
# DMA Destination Address Stepper with Acknowledge Strobe

This block holds the destination address of one DMA channel and moves it after each completed transfer. A two-bit stepping mode picks fixed, ascending or descending addressing. A three-bit size code sets the step: 1, 2, 4 or 8 bytes for single-beat transfers, or 32 bytes for a burst. A load strobe sets a new start address, and arithmetic wraps modulo 2^ADDR_W.

The block also drives the external acknowledge strobe for the device. When the channel runs with separate read and write bus cycles, one control bit decides which of the two cycles carries the strobe. When the channel runs with one bus cycle per transfer, every transfer cycle carries it. A polarity bit selects active-high or active-low output, and the idle level follows that choice.

An error flag marks a prohibited stepping mode or an unknown size code. In either case the address does not move. All outputs are registered.

Top module: `dma_dst_stepper`

## Requirements
- R1: When `xfer_done` is high and `load_en` is low, `dst_addr` changes on the next edge as set by `dst_mode`: 2'b00 keeps it fixed, 2'b01 adds the step, 2'b10 subtracts the step.
- R2: `dst_mode` = 2'b11 sets `cfg_err` high on the next edge, and `dst_addr` does not change on `xfer_done`.
- R3: The step is taken from `xfer_size`: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b100 gives 32 (burst). The same step applies in both directions.
- R4: `xfer_size` codes 3'b101 to 3'b111 set `cfg_err` high on the next edge, and `dst_addr` does not change on `xfer_done`.
- R5: When `single_addr` = 1 and `mem_to_dev` = 1, `dst_mode` has no effect and `dst_addr` does not change on `xfer_done`.
- R6: When `single_addr` = 0, `dack` is asserted for one cycle after each cycle with `rd_cyc` high if `ack_on_write` = 0, or after each cycle with `wr_cyc` high if `ack_on_write` = 1. The other strobe does not assert it.
- R7: When `single_addr` = 1, `dack` is asserted for one cycle after each cycle with `rd_cyc` or `wr_cyc` high, whatever the value of `ack_on_write`.
- R8: With `ack_active_low` = 0, `dack` is 1 when asserted and 0 when idle. With `ack_active_low` = 1, it is 0 when asserted and 1 when idle.
- R9: `load_en` writes `load_addr` into `dst_addr` on the next edge. It takes priority over a `xfer_done` in the same cycle. Stepping wraps modulo 2^ADDR_W.
- R10: While `rst` is high (synchronous), `dst_addr` resets to 0, `cfg_err` to 0, and `dack` to the idle level for the current `ack_active_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_on_write | input | 1 | Two-cycle transfers: 0 = strobe in the read cycle, 1 = strobe in the write cycle |
| ack_active_low | input | 1 | Strobe polarity: 0 = active high, 1 = active low |
| dst_mode | input | 2 | Stepping mode: 00 fixed, 01 ascend, 10 descend, 11 prohibited |
| xfer_size | input | 3 | Size code: 000 8-bit, 001 16-bit, 010 32-bit, 011 64-bit, 100 32-byte burst |
| single_addr | input | 1 | 1 = single bus cycle per transfer |
| mem_to_dev | input | 1 | 1 = transfer moves data from memory to an external device |
| load_en | input | 1 | Load the start address |
| load_addr | input | ADDR_W | Start address |
| rd_cyc | input | 1 | Read bus cycle in progress |
| wr_cyc | input | 1 | Write bus cycle in progress |
| xfer_done | input | 1 | A transfer completed this cycle |
| dst_addr | output | ADDR_W | Current destination address |
| dack | output | 1 | Acknowledge strobe pin |
| cfg_err | output | 1 | Prohibited mode or unknown size code |

## Verification
A wrong step table or a wrong direction shows on `dst_addr` one edge after a single `xfer_done`. The bench therefore loads a base address before every transfer, so a wrong step cannot be hidden by the steps before it. A wrong strobe qualification or polarity shows on `dack` one edge after the strobe, and the idle level is visible in every cycle without a strobe. A missed error decode shows both as a low `cfg_err` and as an address that moved when it should not have.

// File: rtl/dstep_pkg.sv
package dstep_pkg;
  typedef enum logic [1:0] {
    DM_FIXED = 2'b00,
    DM_UP    = 2'b01,
    DM_DOWN  = 2'b10,
    DM_BAD   = 2'b11
  } dst_mode_e;

  localparam int unsigned SIZE_W      = 3;
  localparam int unsigned BEAT_CODES  = 4;
  localparam logic [SIZE_W-1:0] SZ_BURST = 3'b100;
endpackage

// File: rtl/dstep_step_calc.sv
module dstep_step_calc #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BURST_BYTES = 32
) (
  input  logic [1:0]               dst_mode,
  input  logic [dstep_pkg::SIZE_W-1:0] xfer_size,
  input  logic                     skip_step,
  output logic [ADDR_W-1:0]        step,
  output logic                     step_down,
  output logic                     step_en,
  output logic                     cfg_bad
);
  import dstep_pkg::*;

  logic [ADDR_W-1:0] beat_step [BEAT_CODES];
  logic              size_ok;
  logic              mode_bad;

  for (genvar g = 0; g < BEAT_CODES; g++) begin : g_beat
    assign beat_step[g] = ADDR_W'(1) << g;
  end

  always_comb begin
    size_ok = 1'b1;
    step    = '0;
    if (xfer_size < SIZE_W'(BEAT_CODES)) begin
      step = beat_step[xfer_size[1:0]];
    end else if (xfer_size == SZ_BURST) begin
      step = ADDR_W'(BURST_BYTES);
    end else begin
      size_ok = 1'b0;
    end
  end

  assign mode_bad  = (dst_mode_e'(dst_mode) == DM_BAD);
  assign cfg_bad   = mode_bad | ~size_ok;
  assign step_down = (dst_mode_e'(dst_mode) == DM_DOWN);
  assign step_en   = ~cfg_bad & ~skip_step & (dst_mode_e'(dst_mode) != DM_FIXED);
endmodule

// File: rtl/dstep_addr_reg.sv
module dstep_addr_reg #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              advance,
  input  logic              step_down,
  input  logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_next;

  always_comb begin
    addr_next = addr_q;
    if (load_en) begin
      addr_next = load_addr;
    end else if (advance) begin
      addr_next = step_down ? (addr_q - step) : (addr_q + step);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_next;
  end

  assign addr = addr_q;
endmodule

// File: rtl/dstep_ack_gen.sv
module dstep_ack_gen (
  input  logic clk,
  input  logic rst,
  input  logic single_addr,
  input  logic ack_on_write,
  input  logic ack_active_low,
  input  logic rd_cyc,
  input  logic wr_cyc,
  output logic dack
);
  logic qualify;
  logic dack_q;

  always_comb begin
    if (single_addr) qualify = rd_cyc | wr_cyc;
    else             qualify = ack_on_write ? wr_cyc : rd_cyc;
  end

  always_ff @(posedge clk) begin
    if (rst) dack_q <= ack_active_low;
    else     dack_q <= qualify ^ ack_active_low;
  end

  assign dack = dack_q;
endmodule

// File: rtl/dma_dst_stepper.sv
module dma_dst_stepper #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BURST_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_on_write,
  input  logic              ack_active_low,
  input  logic [1:0]        dst_mode,
  input  logic [2:0]        xfer_size,
  input  logic              single_addr,
  input  logic              mem_to_dev,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              rd_cyc,
  input  logic              wr_cyc,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              dack,
  output logic              cfg_err
);
  logic [ADDR_W-1:0] step;
  logic              step_down;
  logic              step_en;
  logic              cfg_bad;
  logic              cfg_err_q;

  dstep_step_calc #(.ADDR_W(ADDR_W), .BURST_BYTES(BURST_BYTES)) u_calc (
    .dst_mode  (dst_mode),
    .xfer_size (xfer_size),
    .skip_step (single_addr & mem_to_dev),
    .step      (step),
    .step_down (step_down),
    .step_en   (step_en),
    .cfg_bad   (cfg_bad)
  );

  dstep_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_addr (load_addr),
    .advance   (xfer_done & step_en),
    .step_down (step_down),
    .step      (step),
    .addr      (dst_addr)
  );

  dstep_ack_gen u_ack (
    .clk            (clk),
    .rst            (rst),
    .single_addr    (single_addr),
    .ack_on_write   (ack_on_write),
    .ack_active_low (ack_active_low),
    .rd_cyc         (rd_cyc),
    .wr_cyc         (wr_cyc),
    .dack           (dack)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err_q <= 1'b0;
    else     cfg_err_q <= cfg_bad;
  end

  assign cfg_err = cfg_err_q;
endmodule

// File: rtl/dstep_checker.sv
module dstep_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ack_active_low,
  input logic [1:0]        dst_mode,
  input logic [2:0]        xfer_size,
  input logic              single_addr,
  input logic              mem_to_dev,
  input logic              load_en,
  input logic [ADDR_W-1:0] load_addr,
  input logic              rd_cyc,
  input logic              wr_cyc,
  input logic              xfer_done,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              dack,
  input logic              cfg_err
);
  p_fixed_r1: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !load_en && dst_mode == 2'b00) |=> $stable(dst_addr));

  p_bad_mode_err_r2: assert property (@(posedge clk) disable iff (rst)
    (dst_mode == 2'b11) |=> cfg_err);

  p_bad_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !load_en && dst_mode == 2'b11) |=> $stable(dst_addr));

  p_word_up_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !load_en && dst_mode == 2'b01 && xfer_size == 3'b010 &&
     !(single_addr && mem_to_dev)) |=> dst_addr == $past(dst_addr) + ADDR_W'(4));

  p_bad_size_err_r4: assert property (@(posedge clk) disable iff (rst)
    (xfer_size > 3'b100) |=> cfg_err);

  p_single_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !load_en && single_addr && mem_to_dev) |=> $stable(dst_addr));

  p_single_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (single_addr && (rd_cyc || wr_cyc)) |=> (dack == !$past(ack_active_low)));

  p_idle_level_r8: assert property (@(posedge clk) disable iff (rst)
    (!rd_cyc && !wr_cyc) |=> (dack == $past(ack_active_low)));

  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (dst_addr == $past(load_addr)));
endmodule

bind dma_dst_stepper dstep_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .ack_active_low (ack_active_low),
  .dst_mode       (dst_mode),
  .xfer_size      (xfer_size),
  .single_addr    (single_addr),
  .mem_to_dev     (mem_to_dev),
  .load_en        (load_en),
  .load_addr      (load_addr),
  .rd_cyc         (rd_cyc),
  .wr_cyc         (wr_cyc),
  .xfer_done      (xfer_done),
  .dst_addr       (dst_addr),
  .dack           (dack),
  .cfg_err        (cfg_err)
);

// File: tb/dma_dst_stepper_test.sv
module dma_dst_stepper_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ack_on_write = 1'b0, ack_active_low = 1'b0;
  logic [1:0]  dst_mode = 2'b00;
  logic [2:0]  xfer_size = 3'b000;
  logic        single_addr = 1'b0, mem_to_dev = 1'b0;
  logic        load_en = 1'b0;
  logic [31:0] load_addr = '0;
  logic        rd_cyc = 1'b0, wr_cyc = 1'b0, xfer_done = 1'b0;
  logic [31:0] dst_addr;
  logic        dack, cfg_err;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_dst_stepper uut (
    .clk(clk), .rst(rst), .ack_on_write(ack_on_write), .ack_active_low(ack_active_low),
    .dst_mode(dst_mode), .xfer_size(xfer_size), .single_addr(single_addr),
    .mem_to_dev(mem_to_dev), .load_en(load_en), .load_addr(load_addr),
    .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .xfer_done(xfer_done),
    .dst_addr(dst_addr), .dack(dack), .cfg_err(cfg_err));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic step_case(logic [31:0] base, logic [1:0] m, logic [2:0] sz,
                           logic sg, logic m2d);
    logic        bad;
    logic [31:0] st, exp;
    string       tag;
    @(negedge clk);
    load_en = 1'b1; load_addr = base;
    dst_mode = 2'b00; xfer_size = 3'b000;
    tick();
    @(negedge clk);
    load_en = 1'b0; dst_mode = m; xfer_size = sz;
    single_addr = sg; mem_to_dev = m2d; xfer_done = 1'b1;
    tick();
    bad = (m == 2'b11) || (sz > 3'b100);
    st  = (sz < 3'b100) ? (32'd1 << sz) : 32'd32;
    if (bad || (sg && m2d) || m == 2'b00) exp = base;
    else if (m == 2'b01) exp = base + st;
    else exp = base - st;
    if (m == 2'b11) tag = "R2";
    else if (sz > 3'b100) tag = "R4";
    else if (sg && m2d) tag = "R5";
    else if (m == 2'b00) tag = "R1";
    else tag = "R3";
    check(tag, dst_addr, exp);
    check(bad ? (m == 2'b11 ? "R2" : "R4") : "R1", {31'd0, cfg_err}, {31'd0, bad});
    @(negedge clk);
    xfer_done = 1'b0; single_addr = 1'b0; mem_to_dev = 1'b0;
  endtask

  task automatic ack_case(logic sg, logic aw, logic al, logic rd, logic wr);
    logic act_on;
    @(negedge clk);
    single_addr = sg; ack_on_write = aw; ack_active_low = al;
    rd_cyc = rd; wr_cyc = wr;
    tick();
    act_on = sg ? (rd | wr) : (aw ? wr : rd);
    check(sg ? "R7" : "R6", {31'd0, dack}, {31'd0, act_on ^ al});
    @(negedge clk);
    rd_cyc = 1'b0; wr_cyc = 1'b0;
    tick();
    check("R8", {31'd0, dack}, {31'd0, al});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", dst_addr, 32'h0);
    check("R10", {31'd0, cfg_err}, 32'h0);
    check("R10", {31'd0, dack}, 32'h0);
    @(negedge clk); rst = 1'b0;

    foreach (bases[i]) begin
      for (int m = 0; m < 4; m++)
        for (int sz = 0; sz < 8; sz++)
          for (int p = 0; p < 3; p++)
            step_case(bases[i], 2'(m), 3'(sz), p != 0, p == 2);
    end

    // R9: load beats a same-cycle transfer; wrap both ways
    @(negedge clk);
    load_en = 1'b1; load_addr = 32'hABCD_0000; dst_mode = 2'b01;
    xfer_size = 3'b100; xfer_done = 1'b1;
    tick();
    check("R9", dst_addr, 32'hABCD_0000);
    @(negedge clk); load_en = 1'b0; xfer_done = 1'b0;
    step_case(32'h0, 2'b10, 3'b010, 1'b0, 1'b0);
    step_case(32'hFFFF_FFFF, 2'b01, 3'b000, 1'b0, 1'b0);
    @(negedge clk);
    load_en = 1'b1; load_addr = 32'h0000_0000; tick();
    @(negedge clk);
    load_en = 1'b0; dst_mode = 2'b10; xfer_size = 3'b011; xfer_done = 1'b1; tick();
    check("R9", dst_addr, 32'hFFFF_FFF8);
    @(negedge clk); dst_mode = 2'b01; tick();
    check("R9", dst_addr, 32'h0);
    @(negedge clk); xfer_done = 1'b0; dst_mode = 2'b00;

    for (int c = 0; c < 32; c++)
      ack_case(c[4], c[3], c[2], c[1], c[0]);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [31:0] bases [3] = '{32'h0000_1000, 32'hFFFF_FFF0, 32'h0000_0010};

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule